// File: doc/BRIEF.md
# Standby Entry and Wake-Up Sequencer

This always-on block moves the system between active mode and a low-power standby state. Firmware raises a one-cycle request. The block then checks a set of conditions that would make standby unsafe or useless. If any condition holds, the request is refused and a reason vector tells firmware what to fix before it tries again. If none holds, the block asks the contact-card interface to deactivate and waits for its acknowledgement. Only then does it raise the standby control.

While in standby, the block watches the wake sources that firmware has enabled, together with a 6-bit tick-based wake timer. Loss of the pad supply is always a wake source. The first wake event, and any others that arrive in the same cycle, are recorded in a sticky wake-reason vector. The block then returns to active mode by driving a level-sensitive system reset generator that stretches its pulse past the release of its source.

A wake condition that appears while deactivation is still in progress cancels the entry. In that case the block goes back to active mode without a reset.

Top module: `stby_seq`

## Requirements
- R1: After reset, `standby_o`, `deact_req_o` and `sys_rst_o` are low, and `prev_rsn_o` and `wake_rsn_o` are zero.
- R2: A request made while any bit of `prev_i` is high is refused. `deact_req_o` and `standby_o` stay low, and `prev_rsn_o[5:0]` shows a copy of `prev_i` two cycles after the request is sampled.
- R3: When `wake_en_i` is zero and `tmr_match_i` is zero, a request is refused with `prev_rsn_o[7]` set.
- R4: A request is refused with `prev_rsn_o[8]` set when any wake event is already present at the check. `prev_rsn_o[6]` is also set when host wake is enabled (`wake_en_i[0]`) but `pad_ok_i` is low.
- R5: A request with no refusal reason raises `deact_req_o` two cycles after the request is sampled, and clears `prev_rsn_o`.
- R6: `standby_o` rises and `deact_req_o` falls in the cycle after `deact_ack_i` is sampled high.
- R7: An enabled wake event during deactivation returns the block to active mode. `standby_o` stays low, `sys_rst_o` gives no pulse, and `wake_rsn_o` is not changed.
- R8: In standby, a masked source has no effect. An enabled source ends standby on the next edge and sets its bit in `wake_rsn_o`. The bits are: 0 host (only with `pad_ok_i` high), 1 card event, 2 RF field, 3 temperature back in range, and 4 rising edge on the GPIO input `wake_src_i[4]`.
- R9: A low `pad_ok_i` during standby always ends standby and sets `wake_rsn_o[6]`, whatever the value of `wake_en_i`.
- R10: With a nonzero match value M, the timer ends standby after exactly M*TICK_DIV+1 cycles of `standby_o` high and sets `wake_rsn_o[5]`. A match value of 0 never causes a wake.
- R11: Each wake from standby gives a `sys_rst_o` pulse of exactly RST_HOLD+1 cycles. The pulse starts in the first cycle after `standby_o` falls.
- R12: `wake_rsn_o` bits stay set until a one is written to the same bit position of `wake_clr_i`. Bits cleared with a zero are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Firmware standby request pulse |
| prev_i | input | 6 | External prevention flags: no host selected, GPIO irq pending, card detect, aux contact irq, deactivation busy, temperature fall seen |
| wake_src_i | input | 5 | Wake conditions: host, card, RF, temperature, GPIO level |
| wake_en_i | input | 5 | Enable mask for `wake_src_i` |
| pad_ok_i | input | 1 | Host pad supply present |
| tmr_match_i | input | TMR_W | Wake timer match value, 0 disables |
| deact_ack_i | input | 1 | Card deactivation finished |
| wake_clr_i | input | 7 | Write-one-to-clear for `wake_rsn_o` |
| standby_o | output | 1 | System standby control |
| deact_req_o | output | 1 | Card deactivation request |
| sys_rst_o | output | 1 | Stretched wake-up system reset |
| prev_rsn_o | output | 9 | Refusal reasons of the last check |
| wake_rsn_o | output | 7 | Sticky wake reasons |

## Verification
A request that the block samples at one edge shows its result in the refusal reasons or in `deact_req_o` after the second edge. `standby_o` changes one edge after the acknowledgement is sampled. A wake input ends standby and updates the reason vector on the next edge, and the reset pulse starts one edge after that. The bench drives all inputs on falling edges and samples exactly at the falling edge where each result is due. It measures the timer interval and the reset pulse length by counting high samples and compares each count with the exact expected number.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int N_EXT    = 5;   // external wake sources
  localparam int N_EVT    = 7;   // all wake events
  localparam int N_PRV_IN = 6;   // external prevention flags
  localparam int N_RSN    = 9;   // refusal reason bits

  localparam int EV_HOST  = 0;
  localparam int EV_GPIO  = 4;
  localparam int EV_TMR   = 5;
  localparam int EV_PAD   = 6;

  localparam int RS_HPAD  = 6;
  localparam int RS_NOSRC = 7;
  localparam int RS_PEND  = 8;

  typedef enum logic [2:0] {
    ST_ACT, ST_CHK, ST_DEACT, ST_STBY, ST_WRST
  } stby_st_e;
endpackage

// File: rtl/stby_wake_evt.sv
module stby_wake_evt
  import stby_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] src_i,
  input  logic [N_EXT-1:0] en_i,
  input  logic             pad_ok_i,
  input  logic             tmr_hit_i,
  output logic [N_EVT-1:0] evt_o
);
  logic gpio_q;

  always_ff @(posedge clk) begin
    if (rst) gpio_q <= 1'b0;
    else     gpio_q <= src_i[EV_GPIO];
  end

  assign evt_o[EV_HOST] = src_i[EV_HOST] & en_i[EV_HOST] & pad_ok_i;

  for (genvar i = 1; i < EV_GPIO; i++) begin : g_lvl
    assign evt_o[i] = src_i[i] & en_i[i];
  end

  assign evt_o[EV_GPIO] = src_i[EV_GPIO] & ~gpio_q & en_i[EV_GPIO];
  assign evt_o[EV_TMR]  = tmr_hit_i;
  assign evt_o[EV_PAD]  = ~pad_ok_i;
endmodule

// File: rtl/stby_wtimer.sv
module stby_wtimer #(
  parameter int TICK_DIV = 15200,
  parameter int TMR_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [TMR_W-1:0] match_i,
  output logic             hit_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign hit_o = run_i && (match_i != '0) && (cnt_q == match_i);

  AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/stby_rst_stretch.sv
module stby_rst_stretch #(
  parameter int NSRC     = 1,
  parameter int RST_HOLD = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  output logic            rst_o
);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic [HW-1:0] hold_q;
  logic          any_src;

  assign any_src = |src_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      rst_o  <= 1'b0;
    end else begin
      rst_o <= any_src || (hold_q != '0);
      if (any_src)             hold_q <= HW'(RST_HOLD);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  AST_RST_WHILE_SRC: assert property (@(posedge clk) disable iff (rst)
    any_src |=> rst_o); // R11
  AST_RST_HOLD_AFTER: assert property (@(posedge clk) disable iff (rst)
    (!any_src && $past(any_src)) |-> rst_o); // R11
endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int TICK_DIV = 15200,
  parameter int TMR_W    = 6,
  parameter int RST_HOLD = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic [N_PRV_IN-1:0] prev_i,
  input  logic [N_EXT-1:0]    wake_src_i,
  input  logic [N_EXT-1:0]    wake_en_i,
  input  logic                pad_ok_i,
  input  logic [TMR_W-1:0]    tmr_match_i,
  input  logic                deact_ack_i,
  input  logic [N_EVT-1:0]    wake_clr_i,
  output logic                standby_o,
  output logic                deact_req_o,
  output logic                sys_rst_o,
  output logic [N_RSN-1:0]    prev_rsn_o,
  output logic [N_EVT-1:0]    wake_rsn_o
);
  stby_st_e          st_q;
  logic [N_EVT-1:0]  evt;
  logic [N_RSN-1:0]  rsn;
  logic [N_EVT-1:0]  wake_q;
  logic [N_RSN-1:0]  prev_q;
  logic              tmr_hit;
  logic              in_stby;
  logic              wrst_src;

  assign in_stby  = (st_q == ST_STBY);
  assign wrst_src = (st_q == ST_WRST);

  stby_wtimer #(.TICK_DIV(TICK_DIV), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .run_i(in_stby), .match_i(tmr_match_i), .hit_o(tmr_hit)
  );

  stby_wake_evt u_evt (
    .clk(clk), .rst(rst), .src_i(wake_src_i), .en_i(wake_en_i),
    .pad_ok_i(pad_ok_i), .tmr_hit_i(tmr_hit), .evt_o(evt)
  );

  stby_rst_stretch #(.NSRC(1), .RST_HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst(rst), .src_i(wrst_src), .rst_o(sys_rst_o)
  );

  // refusal reasons evaluated in the check state
  always_comb begin
    rsn = '0;
    rsn[N_PRV_IN-1:0] = prev_i;
    rsn[RS_HPAD]  = wake_en_i[EV_HOST] & ~pad_ok_i;
    rsn[RS_NOSRC] = (wake_en_i == '0) && (tmr_match_i == '0);
    rsn[RS_PEND]  = |evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_ACT;
      prev_q <= '0;
    end else begin
      case (st_q)
        ST_ACT:   if (req_i) st_q <= ST_CHK;
        ST_CHK: begin
          prev_q <= rsn;
          st_q   <= (|rsn) ? ST_ACT : ST_DEACT;
        end
        ST_DEACT: begin
          if (|evt)             st_q <= ST_ACT;
          else if (deact_ack_i) st_q <= ST_STBY;
        end
        ST_STBY:  if (|evt) st_q <= ST_WRST;
        ST_WRST:  st_q <= ST_ACT;
        default:  st_q <= ST_ACT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wake_q <= '0;
    else     wake_q <= (wake_q & ~wake_clr_i) | (in_stby ? evt : '0);
  end

  assign standby_o   = in_stby;
  assign deact_req_o = (st_q == ST_DEACT);
  assign prev_rsn_o  = prev_q;
  assign wake_rsn_o  = wake_q;

  AST_STBY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_o) |-> ($past(deact_ack_i) && $past(deact_req_o))); // R6
  AST_RST_ONLY_FROM_STBY: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(standby_o, 2)); // R7
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wake_clr_i == '0) |=> ((wake_rsn_o & $past(wake_rsn_o)) == $past(wake_rsn_o))); // R12
  AST_NO_STBY_ON_REFUSE: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_CHK) && (|prev_i)) |=> !deact_req_o); // R2
endmodule

// File: tb/stby_seq_tb_top.sv
module stby_seq_tb_top;
  localparam int TICK_DIV = 4;
  localparam int TMR_W    = 6;
  localparam int RST_HOLD = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_i = 1'b0;
  logic [5:0]       prev_i = '0;
  logic [4:0]       wake_src_i = '0;
  logic [4:0]       wake_en_i = '0;
  logic             pad_ok_i = 1'b1;
  logic [TMR_W-1:0] tmr_match_i = '0;
  logic             deact_ack_i = 1'b0;
  logic [6:0]       wake_clr_i = '0;
  logic             standby_o, deact_req_o, sys_rst_o;
  logic [8:0]       prev_rsn_o;
  logic [6:0]       wake_rsn_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  stby_seq #(.TICK_DIV(TICK_DIV), .TMR_W(TMR_W), .RST_HOLD(RST_HOLD)) dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .prev_i(prev_i), .wake_src_i(wake_src_i),
    .wake_en_i(wake_en_i), .pad_ok_i(pad_ok_i), .tmr_match_i(tmr_match_i),
    .deact_ack_i(deact_ack_i), .wake_clr_i(wake_clr_i), .standby_o(standby_o),
    .deact_req_o(deact_req_o), .sys_rst_o(sys_rst_o), .prev_rsn_o(prev_rsn_o),
    .wake_rsn_o(wake_rsn_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) req_i = 1'b1;
    @(negedge clk) req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic enter_ok();
    pulse_req();
    check("R5 deact_req raised", int'(deact_req_o), 1);
    check("R5 reasons cleared", int'(prev_rsn_o), 0);
    deact_ack_i = 1'b1;
    @(negedge clk) deact_ack_i = 1'b0;
    check("R6 standby raised", int'(standby_o), 1);
    check("R6 deact_req dropped", int'(deact_req_o), 0);
  endtask

  // called at the negedge where standby_o was first seen low
  task automatic measure_rst();
    int n = 0;
    @(negedge clk);
    for (int k = 0; k < 50 && sys_rst_o; k++) begin
      n++;
      @(negedge clk);
    end
    check("R11 reset pulse width", n, RST_HOLD + 1);
  endtask

  task automatic clear_wake();
    @(negedge clk) wake_clr_i = 7'h7f;
    @(negedge clk) wake_clr_i = '0;
  endtask

  task automatic t_reset();
    check("R1 standby", int'(standby_o), 0);
    check("R1 deact_req", int'(deact_req_o), 0);
    check("R1 sys_rst", int'(sys_rst_o), 0);
    check("R1 prev_rsn", int'(prev_rsn_o), 0);
    check("R1 wake_rsn", int'(wake_rsn_o), 0);
  endtask

  task automatic t_refuse();
    wake_en_i = 5'b00100;
    prev_i = 6'b000100;
    pulse_req();
    check("R2 reason card detect", int'(prev_rsn_o), 'h004);
    check("R2 no deactivation", int'(deact_req_o), 0);
    prev_i = 6'b100001;
    pulse_req();
    check("R2 reason two flags", int'(prev_rsn_o), 'h021);
    check("R2 no standby", int'(standby_o), 0);
    prev_i = '0;
  endtask

  task automatic t_nosrc();
    wake_en_i = '0;
    tmr_match_i = '0;
    pulse_req();
    check("R3 no wake source", int'(prev_rsn_o), 'h080);
  endtask

  task automatic t_pend();
    wake_en_i = 5'b00100;
    wake_src_i = 5'b00100;
    pulse_req();
    check("R4 pending wake", int'(prev_rsn_o), 'h100);
    wake_src_i = '0;
    wake_en_i = 5'b00001;
    pad_ok_i = 1'b0;
    pulse_req();
    check("R4 host pad missing", int'(prev_rsn_o), 'h140);
    pad_ok_i = 1'b1;
  endtask

  task automatic t_abort();
    wake_en_i = 5'b00100;
    pulse_req();
    check("R7 in deactivation", int'(deact_req_o), 1);
    wake_src_i = 5'b00100;
    @(negedge clk);
    check("R7 deactivation aborted", int'(deact_req_o), 0);
    wake_src_i = '0;
    for (int k = 0; k < 5; k++) begin
      check("R7 no reset pulse", int'(sys_rst_o | standby_o), 0);
      @(negedge clk);
    end
    check("R7 wake reasons untouched", int'(wake_rsn_o), 0);
  endtask

  task automatic t_gpio();
    wake_en_i = 5'b10000;
    enter_ok();
    wake_src_i = 5'b00010;   // card event, masked
    repeat (3) @(negedge clk);
    check("R8 masked source ignored", int'(standby_o), 1);
    check("R8 masked reason clear", int'(wake_rsn_o), 0);
    wake_src_i = 5'b10010;   // gpio rises
    @(negedge clk);
    check("R8 gpio wake", int'(standby_o), 0);
    check("R8 gpio reason", int'(wake_rsn_o), 'h10);
    measure_rst();
    wake_src_i = '0;
    clear_wake();
    check("R12 cleared", int'(wake_rsn_o), 0);
  endtask

  task automatic t_padloss();
    wake_en_i = '0;
    tmr_match_i = 6'd20;
    enter_ok();
    pad_ok_i = 1'b0;
    @(negedge clk);
    check("R9 pad loss wake", int'(standby_o), 0);
    check("R9 pad loss reason", int'(wake_rsn_o), 'h40);
    measure_rst();
    pad_ok_i = 1'b1;
    clear_wake();
  endtask

  task automatic t_timer();
    int n;
    wake_en_i = '0;
    tmr_match_i = 6'd3;
    enter_ok();
    n = 1;
    @(negedge clk);
    for (int k = 0; k < 1000 && standby_o; k++) begin
      n++;
      @(negedge clk);
    end
    check("R10 timer interval", n, 3 * TICK_DIV + 1);
    check("R10 timer reason", int'(wake_rsn_o), 'h20);
    measure_rst();
    clear_wake();
    tmr_match_i = '0;
    wake_en_i = 5'b00100;
    enter_ok();
    repeat (300) @(negedge clk);
    check("R10 zero match no wake", int'(standby_o), 1);
    wake_src_i = 5'b00100;
    @(negedge clk);
    check("R8 rf wake", int'(wake_rsn_o), 'h04);
    wake_src_i = '0;
    measure_rst();
  endtask

  task automatic t_w1c();
    @(negedge clk) wake_clr_i = 7'h01;
    @(negedge clk) wake_clr_i = '0;
    check("R12 other bit kept", int'(wake_rsn_o), 'h04);
    @(negedge clk) wake_clr_i = 7'h04;
    @(negedge clk) wake_clr_i = '0;
    check("R12 bit cleared", int'(wake_rsn_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_nosrc();
    t_pend();
    t_abort();
    t_gpio();
    t_padloss();
    t_timer();
    t_w1c();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule